// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block moves whole bytes over a three-wire synchronous link: a bit clock (SCK), a data output (TxD) and a data input (RxD). Each transfer is exactly eight data bits, least significant bit first. There are no start, stop or parity bits. Every byte shifted out is matched by a byte shifted in. The host writes outgoing bytes into a 64-entry transmit queue and reads incoming bytes from a 64-entry receive queue. The fill level of each queue can be read at any time.

A single select input decides who owns the bit clock. When the select is high, the port is clock master. A programmable divider sets the SCK half-period, and SCK is driven out through an output-enable. SCK rests high while nothing is queued, and the port streams queued bytes back to back with no idle time between them. When the select is low, SCK is an input. The port follows the synchronized edges of the incoming clock. If the transmit queue is empty at the start of a byte, the port sends all ones.

Top module: `sync_serial_port`

## Requirements
- R1: Bits travel least significant first, 8 per byte, with no framing bits. TxD changes only on a falling SCK edge, and RxD is captured on a rising SCK edge. In master mode the byte is captured on the rising edge that is internal to the port. In slave mode it is captured on the rising edge of SCK after synchronization.
- R2: The transmit queue holds up to 64 bytes, and tx_count reports its fill level. When tx_push is asserted while the queue is full, the push is ignored: the count stays at 64 and the pushed byte is never sent.
- R3: The receive queue holds up to 64 bytes. rx_count reports its fill level, and rx_data always shows the oldest entry. A pop of an empty queue has no effect. If a byte completes in the same cycle as a pop of a full queue, the byte is stored, the count stays at 64 and no overrun is flagged.
- R4: With clk_sel high, sck_oe is 1 and each SCK half-period lasts div_half+1 clock cycles. SCK stays high whenever the transmit queue is empty at a byte boundary.
- R5: In master mode, bytes queued before the current byte ends follow it with no gap. Every rising SCK edge is the same 2*(div_half+1) cycles after the previous one.
- R6: With clk_sel low, sck_oe is 0 and the port shifts on the edges of sck_i, which pass through a two-stage synchronizer. A byte completes on every eighth rising edge of sck_i.
- R7: In slave mode, if the transmit queue is empty on the first falling edge of a byte, the byte sent is 0xFF.
- R8: A byte that completes while the receive queue is full and no pop is taking place is dropped. It sets overrun, and overrun stays set until overrun_clr is pulsed.
- R9: After reset, both counts are 0, overrun is 0, and SCK and TxD are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 1: port generates SCK, 0: SCK comes from outside |
| div_half | input | DIVW | SCK half-period minus one, in clock cycles |
| tx_data | input | 8 | Byte to queue for sending |
| tx_push | input | 1 | Write tx_data into the transmit queue |
| tx_count | output | AW+1 | Transmit queue fill level |
| rx_data | output | 8 | Oldest received byte |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_count | output | AW+1 | Receive queue fill level |
| overrun | output | 1 | Sticky lost-byte flag |
| overrun_clr | input | 1 | Clear overrun |
| sck_o | output | 1 | Generated bit clock |
| sck_oe | output | 1 | Drive enable for the SCK pad |
| sck_i | input | 1 | Bit clock from the SCK pad |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
Two functions can collide in the receive queue. The line can finish a byte and write it in the same cycle that the host pops a full queue. The bench produces this collision in slave mode. It fills the receive queue to 64 and then drives the last rising edge of a byte on sck_i. It holds rx_pop high only during the third clock after that edge, which is the cycle the synchronized edge reaches the queue. The bench then requires that overrun stays low, that the count remains 64, and that popping the queue returns the old entries in order with the colliding byte last.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DEPTH = 64,
  parameter int DIVW  = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_sel,
  input  logic [DIVW-1:0] div_half,
  input  logic [7:0]      tx_data,
  input  logic            tx_push,
  output logic [AW:0]     tx_count,
  output logic [7:0]      rx_data,
  input  logic            rx_pop,
  output logic [AW:0]     rx_count,
  output logic            overrun,
  input  logic            overrun_clr,
  output logic            sck_o,
  output logic            sck_oe,
  input  logic            sck_i,
  output logic            txd,
  input  logic            rxd
);
  // DEPTH must be a power of two: pointers wrap naturally.
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [7:0]      tx_mem [DEPTH];
  logic [7:0]      rx_mem [DEPTH];
  logic [AW-1:0]   tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]     tx_cnt, rx_cnt;
  logic [DIVW-1:0] divcnt;
  logic            sck_r;
  logic [2:0]      ss;
  logic [2:0]      bitcnt;
  logic [7:0]      tx_sh, rx_sh;

  // bit clock strobes
  wire idle   = sck_r && bitcnt == 3'd0 && tx_cnt == '0;
  wire tick   = clk_sel && !idle && divcnt == div_half;
  wire fall   = clk_sel ? (tick && sck_r)  : (!ss[1] && ss[2]);
  wire rise   = clk_sel ? (tick && !sck_r) : (ss[1] && !ss[2]);

  // queue controls
  wire tx_wr  = tx_push && tx_cnt != FULL;
  wire tx_rd  = fall && bitcnt == 3'd0 && tx_cnt != '0;
  wire rx_rd  = rx_pop && rx_cnt != '0;
  wire rx_fin = rise && bitcnt == 3'd7;
  wire rx_wr  = rx_fin && (rx_cnt != FULL || rx_rd);
  wire [7:0] rx_byte = {rxd, rx_sh[7:1]};

  assign tx_count = tx_cnt;
  assign rx_count = rx_cnt;
  assign rx_data  = rx_mem[rx_rp];
  assign sck_o    = sck_r;
  assign sck_oe   = clk_sel;

  always_ff @(posedge clk) begin
    if (tx_wr) tx_mem[tx_wp] <= tx_data;
    if (rx_wr) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      overrun <= 1'b0;
    end else begin
      if (tx_wr) tx_wp <= tx_wp + 1'b1;
      if (tx_rd) tx_rp <= tx_rp + 1'b1;
      if (tx_wr != tx_rd) tx_cnt <= tx_wr ? tx_cnt + 1'b1 : tx_cnt - 1'b1;
      if (rx_wr) rx_wp <= rx_wp + 1'b1;
      if (rx_rd) rx_rp <= rx_rp + 1'b1;
      if (rx_wr != rx_rd) rx_cnt <= rx_wr ? rx_cnt + 1'b1 : rx_cnt - 1'b1;
      if (rx_fin && !rx_wr) overrun <= 1'b1;
      else if (overrun_clr) overrun <= 1'b0;
    end
  end

  // clock generation and external clock synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divcnt <= '0;
      sck_r  <= 1'b1;
      ss     <= 3'b111;
    end else begin
      ss <= {ss[1:0], sck_i};
      if (!clk_sel || idle) begin
        divcnt <= '0;
        if (!clk_sel) sck_r <= 1'b1;
      end else if (divcnt == div_half) begin
        divcnt <= '0;
        sck_r  <= ~sck_r;
      end else begin
        divcnt <= divcnt + 1'b1;
      end
    end
  end

  // shifters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      tx_sh  <= 8'hFF;
      rx_sh  <= '0;
      txd    <= 1'b1;
    end else begin
      if (fall) begin
        if (bitcnt == 3'd0) begin
          if (tx_cnt != '0) begin
            txd   <= tx_mem[tx_rp][0];
            tx_sh <= {1'b1, tx_mem[tx_rp][7:1]};
          end else begin
            txd   <= 1'b1;
            tx_sh <= 8'hFF;
          end
        end else begin
          txd   <= tx_sh[0];
          tx_sh <= {1'b1, tx_sh[7:1]};
        end
      end
      if (rise) begin
        rx_sh  <= rx_byte;
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  a_r1_txd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(txd));
  a_r2_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL);
  a_r3_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL);
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel && sck_r && bitcnt == 3'd0 && tx_cnt == '0 |=> sck_o);
  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fin && rx_cnt == FULL && !rx_pop |=> overrun);
endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_sel = 1'b1;
  logic [15:0] div_half = 16'd2;
  logic [7:0]  tx_data = '0;
  logic        tx_push = 1'b0;
  logic [6:0]  tx_count;
  logic [7:0]  rx_data;
  logic        rx_pop = 1'b0;
  logic [6:0]  rx_count;
  logic        overrun;
  logic        overrun_clr = 1'b0;
  logic        sck_o, sck_oe;
  logic        sck_i = 1'b1;
  logic        txd;
  logic        rxd = 1'b1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sync_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .div_half(div_half),
    .tx_data(tx_data), .tx_push(tx_push), .tx_count(tx_count),
    .rx_data(rx_data), .rx_pop(rx_pop), .rx_count(rx_count),
    .overrun(overrun), .overrun_clr(overrun_clr),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .txd(txd), .rxd(rxd)
  );

  // master-mode line partner
  bit        bits[$];
  logic [7:0] got[$];
  logic [7:0] mon_sh;
  int        mon_n, rises;
  time       last_rise, iv_min, iv_max;

  always @(posedge sck_o) if (sck_oe) begin
    mon_sh = {txd, mon_sh[7:1]};
    mon_n++;
    if (mon_n == 8) begin got.push_back(mon_sh); mon_n = 0; end
    if (last_rise != 0) begin
      if ($time - last_rise < iv_min) iv_min = $time - last_rise;
      if ($time - last_rise > iv_max) iv_max = $time - last_rise;
    end
    last_rise = $time;
    rises++;
  end

  always @(negedge sck_o) if (sck_oe)
    rxd = (bits.size() > 0) ? bits.pop_front() : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    tx_data = d; tx_push = 1;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop(output logic [7:0] d);
    d = rx_data; rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  // one slave-mode byte; optional pop lined up with the final rising edge
  task automatic ext_byte(input logic [7:0] rb, input bit pop_last,
                          output logic [7:0] tb, output logic [7:0] popped);
    popped = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sck_i = 0; rxd = rb[i];
      repeat (6) @(negedge clk);
      tb[i] = txd;
      sck_i = 1;
      if (i == 7 && pop_last) begin
        @(negedge clk); @(negedge clk);
        popped = rx_data; rx_pop = 1;
        @(negedge clk); rx_pop = 0;
        repeat (3) @(negedge clk);
      end else begin
        repeat (6) @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    clk_sel = 1;
    do_reset();
    check(tx_count == 0 && rx_count == 0, "R9 counts", {tx_count, rx_count}, 0);
    check(sck_o == 1 && txd == 1 && overrun == 0, "R9 pins", {sck_o, txd, overrun}, 3'b110);
  endtask

  task automatic t_master(input int div);
    logic [7:0] txb[3] = '{8'h5A, 8'hC3, 8'h81};
    logic [7:0] rxb[3] = '{8'h96, 8'h0F, 8'hE1};
    logic [7:0] d;
    int r0, w;
    clk_sel = 1; div_half = 16'(div);
    do_reset();
    bits.delete(); got.delete();
    mon_n = 0; rises = 0; last_rise = 0; iv_min = 1000000; iv_max = 0;
    for (int b = 0; b < 3; b++) for (int i = 0; i < 8; i++) bits.push_back(rxb[b][i]);
    check(sck_oe == 1, "R4 drives sck", sck_oe, 1);
    for (int b = 0; b < 3; b++) push(txb[b]);
    w = 0;
    while (got.size() < 3 && w < 3000) begin @(negedge clk); w++; end
    check(got.size() == 3, "R5 bytes out", got.size(), 3);
    for (int b = 0; b < 3; b++)
      check(b < got.size() && got[b] == txb[b], "R1 tx byte", (b < got.size()) ? got[b] : 0, txb[b]);
    check(iv_min == iv_max && iv_max == 2 * (div + 1) * 10, "R5 no gap",
          int'(iv_max), 2 * (div + 1) * 10);
    repeat (2 * (div + 1)) @(negedge clk);
    r0 = rises;
    repeat (40) begin
      @(negedge clk);
      if (sck_o !== 1'b1) r0 = -1;
    end
    check(r0 == rises, "R4 idle high", r0, rises);
    check(tx_count == 0, "R2 drained", tx_count, 0);
    check(rx_count == 3, "R3 rx count", rx_count, 3);
    for (int b = 0; b < 3; b++) begin
      pop(d);
      check(d == rxb[b], "R1 rx byte", d, rxb[b]);
    end
  endtask

  task automatic t_slave();
    logic [7:0] tb, pp, d;
    clk_sel = 0; sck_i = 1;
    do_reset();
    check(sck_oe == 0, "R6 sck input", sck_oe, 0);
    for (int i = 0; i < 65; i++) push(8'(i * 3 + 1));
    check(tx_count == 64, "R2 full holds 64", tx_count, 64);
    for (int i = 0; i < 64; i++) begin
      ext_byte(8'hA5 ^ 8'(i), 0, tb, pp);
      check(tb == 8'(i * 3 + 1), "R6 slave tx", tb, 8'(i * 3 + 1));
    end
    check(tx_count == 0 && rx_count == 64 && overrun == 0, "R3 rx full",
          rx_count, 64);
    ext_byte(8'h3C, 0, tb, pp);
    check(tb == 8'hFF, "R7 empty sends ones", tb, 8'hFF);
    check(tb != 8'(64 * 3 + 1), "R2 ignored push not sent", tb, 8'hFF);
    check(overrun == 1 && rx_count == 64, "R8 overrun", overrun, 1);
    @(negedge clk); overrun_clr = 1; @(negedge clk); overrun_clr = 0;
    check(overrun == 0, "R8 clear", overrun, 0);
    ext_byte(8'h77, 1, tb, pp);
    check(pp == 8'hA5, "R3 collide pop head", pp, 8'hA5);
    check(overrun == 0 && rx_count == 64, "R3 collide kept", {overrun, rx_count}, 64);
    for (int i = 1; i < 64; i++) begin
      pop(d);
      check(d == (8'hA5 ^ 8'(i)), "R8 order kept", d, 8'hA5 ^ 8'(i));
    end
    pop(d);
    check(d == 8'h77, "R3 collided byte last", d, 8'h77);
    check(rx_count == 0, "R3 empty", rx_count, 0);
    pop(d);
    check(rx_count == 0, "R3 empty pop ignored", rx_count, 0);
  endtask

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    t_reset();
    t_master(2);
    t_master(0);
    t_slave();
    summary();
  end
endmodule